// File: doc/BRIEF.md
# Register-Window Trap Entry Sequencer

This block carries out trap entry for a processor whose integer registers are organised as overlapping windows. When a trap is requested, it moves the current window pointer back by one window, modulo the window count, and stores the interrupted program counter and next program counter into two local registers of the newly selected window. It uses one register-file write per cycle. It then presents the updated processor state: the new window pointer, the supervisor bit, the previous-supervisor bit and the trap-enable bit. It also presents the trap base register, with the trap number merged in, and the fetch addresses that redirect execution to the trap vector.

A trap requested while traps are disabled is not taken. The sequencer instead drops into a sticky error state, which it leaves only through reset. Trap arbitration and the register file itself belong to the surrounding core. The core supplies one already-chosen trap number and applies the write port and the committed state fields.

The controller has five states:
- `ST_IDLE` waits for a request.
- `ST_SAVE_PC` writes the old pc.
- `ST_SAVE_NPC` writes the old npc.
- `ST_COMMIT` pulses `done` with the new state fields.
- `ST_ERROR` is the sticky error state.

Its transitions:
- IDLE→SAVE_PC on a request with traps enabled (accept).
- IDLE→ERROR on a request with traps disabled (refuse).
- SAVE_PC→SAVE_NPC, SAVE_NPC→COMMIT and COMMIT→IDLE unconditionally (advance).
- ERROR→ERROR until reset (hold).

Top module: `trap_entry_seq`

## Requirements
- R1: A request sampled in idle with `et_in`=0 moves the block to the error state. From the next cycle on, `err_state` is 1, and `rf_we` and `done` stay 0 for every later request until reset.
- R2: The destination window is (`cwp_in` − 1) modulo NWIN, so `cwp_in`=0 gives NWIN−1. This value appears on `rf_win` during both writes and on `new_cwp` during `done`.
- R3: In the first cycle after an accepted request, `rf_we`=1, `rf_local`=1 and `rf_wdata` equals the sampled pc.
- R4: In the second cycle after an accepted request, `rf_we`=1, `rf_local`=2 and `rf_wdata` equals the sampled npc.
- R5: During `done`, `new_psup` equals the sampled `sup_in`, `new_sup`=1 and `new_et`=0.
- R6: During `done`, `new_tbr` bits 31:12 equal the sampled `tbr_base_in`, bits 11:4 equal the sampled `trap_num`, and bits 3:0 are 0.
- R7: During `done`, `new_pc` equals `new_tbr` and `new_npc` equals `new_tbr`+4.
- R8: `done` is high for exactly one cycle, the third cycle after acceptance. `busy` is high in cycles one to three. At most one of `rf_we` and `done` is high in any cycle.
- R9: A request raised while `busy` is high is ignored. It causes no extra write, and its inputs do not alter the results of the trap in progress.
- R10: After reset the block is idle, with `busy`, `rf_we`, `done` and `err_state` all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_req | input | 1 | Trap request, sampled in idle |
| trap_num | input | 8 | Trap type number |
| pc_in | input | 32 | Program counter at the trap |
| npc_in | input | 32 | Next program counter at the trap |
| cwp_in | input | $clog2(NWIN) | Current window pointer |
| sup_in | input | 1 | Current supervisor bit |
| et_in | input | 1 | Trap-enable bit |
| tbr_base_in | input | 20 | Trap base register bits 31:12 |
| busy | output | 1 | Entry sequence in progress |
| rf_we | output | 1 | Register-file write enable |
| rf_win | output | $clog2(NWIN) | Window of the write |
| rf_local | output | 3 | Local register index of the write |
| rf_wdata | output | 32 | Write data |
| done | output | 1 | One-cycle commit strobe for the new state fields |
| new_cwp | output | $clog2(NWIN) | New window pointer |
| new_sup | output | 1 | New supervisor bit |
| new_psup | output | 1 | New previous-supervisor bit |
| new_et | output | 1 | New trap-enable bit |
| new_tbr | output | 32 | Trap base register with the trap number merged in |
| new_pc | output | 32 | Redirected fetch address |
| new_npc | output | 32 | Redirected next fetch address |
| err_state | output | 1 | Sticky error state |

## Verification
The hardest situation to reach is a second request that lands in the middle of an entry sequence with different pc, window and trap values. If the sequencer wrongly sampled it, the writes still under way would be corrupted. The stimulus raises such requests in the cycles right after acceptance, with all inputs changed. A reference model that only accepts requests in idle then exposes any stray write or altered commit. The window wrap is reached by starting from window 0. The sticky error state is reached by requesting with traps disabled, then requesting again, then resetting.

// File: rtl/trap_seq_pkg.sv
package trap_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_SAVE_PC  = 3'd1,
        ST_SAVE_NPC = 3'd2,
        ST_COMMIT   = 3'd3,
        ST_ERROR    = 3'd4
    } seq_state_e;

    localparam logic [2:0] LOC_PC_SLOT  = 3'd1;
    localparam logic [2:0] LOC_NPC_SLOT = 3'd2;

endpackage

// File: rtl/trap_win_step.sv
module trap_win_step #(
    parameter int NWIN  = 8,
    parameter int CWP_W = $clog2(NWIN)
) (
    input  logic [CWP_W-1:0] cwp_cur,
    output logic [CWP_W-1:0] cwp_prev
);
    // NWIN is a power of two, so modulo is the natural wrap of CWP_W bits.
    generate
        if (CWP_W == 1) begin : g_two
            assign cwp_prev = ~cwp_cur;
        end else begin : g_many
            assign cwp_prev = cwp_cur - {{(CWP_W-1){1'b0}}, 1'b1};
        end
    endgenerate
endmodule

// File: rtl/trap_vec_form.sv
module trap_vec_form #(
    parameter int XLEN = 32,
    parameter int TT_W = 8,
    localparam int LOW_W  = TT_W + 4,
    localparam int BASE_W = XLEN - LOW_W
) (
    input  logic [BASE_W-1:0] base_hi,
    input  logic [TT_W-1:0]   tt,
    output logic [XLEN-1:0]   vec,
    output logic [XLEN-1:0]   vec_next
);
    assign vec      = {base_hi, tt, 4'b0000};
    assign vec_next = {base_hi, tt, 4'b0100};
endmodule

// File: rtl/trap_seq_fsm.sv
module trap_seq_fsm
    import trap_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       trap_req,
    input  logic       et_in,
    output seq_state_e state,
    output logic       accept
);
    seq_state_e state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        accept   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (trap_req) begin
                    if (et_in) begin
                        state_nx = ST_SAVE_PC;
                        accept   = 1'b1;
                    end else begin
                        state_nx = ST_ERROR;
                    end
                end
            end
            ST_SAVE_PC:  state_nx = ST_SAVE_NPC;
            ST_SAVE_NPC: state_nx = ST_COMMIT;
            ST_COMMIT:   state_nx = ST_IDLE;
            ST_ERROR:    state_nx = ST_ERROR;
            default:     state_nx = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq
    import trap_seq_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int XLEN = 32,
    parameter int TT_W = 8,
    localparam int CWP_W  = $clog2(NWIN),
    localparam int BASE_W = XLEN - TT_W - 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trap_req,
    input  logic [TT_W-1:0]   trap_num,
    input  logic [XLEN-1:0]   pc_in,
    input  logic [XLEN-1:0]   npc_in,
    input  logic [CWP_W-1:0]  cwp_in,
    input  logic              sup_in,
    input  logic              et_in,
    input  logic [BASE_W-1:0] tbr_base_in,
    output logic              busy,
    output logic              rf_we,
    output logic [CWP_W-1:0]  rf_win,
    output logic [2:0]        rf_local,
    output logic [XLEN-1:0]   rf_wdata,
    output logic              done,
    output logic [CWP_W-1:0]  new_cwp,
    output logic              new_sup,
    output logic              new_psup,
    output logic              new_et,
    output logic [XLEN-1:0]   new_tbr,
    output logic [XLEN-1:0]   new_pc,
    output logic [XLEN-1:0]   new_npc,
    output logic              err_state
);
    seq_state_e        state;
    logic              accept;
    logic [CWP_W-1:0]  cwp_dec;
    logic [XLEN-1:0]   vec, vec_nx;

    // Values captured when the trap is accepted
    logic [XLEN-1:0]   pc_q, npc_q;
    logic [CWP_W-1:0]  win_q;
    logic              psup_q;
    logic [TT_W-1:0]   tt_q;
    logic [BASE_W-1:0] base_q;

    trap_seq_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .trap_req (trap_req),
        .et_in    (et_in),
        .state    (state),
        .accept   (accept)
    );

    trap_win_step #(.NWIN(NWIN)) u_win (
        .cwp_cur  (cwp_in),
        .cwp_prev (cwp_dec)
    );

    trap_vec_form #(.XLEN(XLEN), .TT_W(TT_W)) u_vec (
        .base_hi  (base_q),
        .tt       (tt_q),
        .vec      (vec),
        .vec_next (vec_nx)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q   <= '0;
            npc_q  <= '0;
            win_q  <= '0;
            psup_q <= 1'b0;
            tt_q   <= '0;
            base_q <= '0;
        end else if (accept) begin
            pc_q   <= pc_in;
            npc_q  <= npc_in;
            win_q  <= cwp_dec;
            psup_q <= sup_in;
            tt_q   <= trap_num;
            base_q <= tbr_base_in;
        end
    end

    // Output process: decoded from the state and captured values
    always_comb begin
        busy      = 1'b0;
        rf_we     = 1'b0;
        rf_local  = LOC_PC_SLOT;
        rf_wdata  = pc_q;
        done      = 1'b0;
        err_state = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_SAVE_PC: begin
                busy     = 1'b1;
                rf_we    = 1'b1;
                rf_local = LOC_PC_SLOT;
                rf_wdata = pc_q;
            end
            ST_SAVE_NPC: begin
                busy     = 1'b1;
                rf_we    = 1'b1;
                rf_local = LOC_NPC_SLOT;
                rf_wdata = npc_q;
            end
            ST_COMMIT: begin
                busy = 1'b1;
                done = 1'b1;
            end
            ST_ERROR: err_state = 1'b1;
            default: ;
        endcase
    end

    assign rf_win   = win_q;
    assign new_cwp  = win_q;
    assign new_sup  = 1'b1;
    assign new_psup = psup_q;
    assign new_et   = 1'b0;
    assign new_tbr  = vec;
    assign new_pc   = vec;
    assign new_npc  = vec_nx;
endmodule

// File: rtl/trap_entry_seq_chk.sv
module trap_entry_seq_chk #(
    parameter int CWP_W = 3,
    parameter int XLEN  = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             trap_req,
    input logic             et_in,
    input logic [CWP_W-1:0] cwp_in,
    input logic [XLEN-1:0]  pc_in,
    input logic [XLEN-1:0]  npc_in,
    input logic             busy,
    input logic             rf_we,
    input logic [CWP_W-1:0] rf_win,
    input logic [2:0]       rf_local,
    input logic [XLEN-1:0]  rf_wdata,
    input logic             done,
    input logic [XLEN-1:0]  new_pc,
    input logic [XLEN-1:0]  new_npc,
    input logic             err_state
);
    logic start;
    assign start = trap_req && et_in && !busy && !err_state;

    a_r1_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        err_state |-> (!rf_we && !done && !busy));

    a_r1_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_state |=> err_state);

    a_r2_r3_first_write: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (rf_we && rf_local == 3'd1 && rf_wdata == $past(pc_in)
                   && rf_win == $past(cwp_in) - 1'b1));

    a_r4_second_write: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> ##1 (rf_we && rf_local == 3'd2 && rf_wdata == $past(npc_in, 2)));

    a_r7_vector: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (new_npc == new_pc + 32'd4 && new_pc[3:0] == 4'd0));

    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rf_we, done}));

    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind trap_entry_seq trap_entry_seq_chk #(.CWP_W(CWP_W), .XLEN(XLEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .trap_req  (trap_req),
    .et_in     (et_in),
    .cwp_in    (cwp_in),
    .pc_in     (pc_in),
    .npc_in    (npc_in),
    .busy      (busy),
    .rf_we     (rf_we),
    .rf_win    (rf_win),
    .rf_local  (rf_local),
    .rf_wdata  (rf_wdata),
    .done      (done),
    .new_pc    (new_pc),
    .new_npc   (new_npc),
    .err_state (err_state)
);

// File: tb/tb_trap_entry_seq.sv
module tb_trap_entry_seq;
    localparam int NWIN  = 8;
    localparam int CWP_W = 3;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        trap_req;
    logic [7:0]  trap_num;
    logic [31:0] pc_in, npc_in;
    logic [2:0]  cwp_in;
    logic        sup_in, et_in;
    logic [19:0] tbr_base_in;
    logic        busy, rf_we, done, new_sup, new_psup, new_et, err_state;
    logic [2:0]  rf_win, new_cwp, rf_local;
    logic [31:0] rf_wdata, new_tbr, new_pc, new_npc;

    always #2.5 clk = ~clk;

    trap_entry_seq #(.NWIN(NWIN)) dut (.*);

    int total = 0;
    int bad = 0;
    int cycles = 0;

    // Reference model state: 0 idle, 1..3 sequence steps, 4 error
    int          m_phase;
    logic [31:0] m_pc, m_npc, m_tbr;
    logic [2:0]  m_win;
    logic        m_psup;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_step();
        if (!rst_n) m_phase = 0;
        else begin
            case (m_phase)
                0: if (trap_req) begin
                       if (!et_in) m_phase = 4;
                       else begin
                           m_phase = 1;
                           m_pc    = pc_in;
                           m_npc   = npc_in;
                           m_win   = 3'((int'(cwp_in) + NWIN - 1) % NWIN);
                           m_psup  = sup_in;
                           m_tbr   = (32'(tbr_base_in) << 12) | (32'(trap_num) << 4);
                       end
                   end
                1: m_phase = 2;
                2: m_phase = 3;
                3: m_phase = 0;
                default: m_phase = 4;
            endcase
        end
    endtask

    task automatic compare();
        chk(busy == (m_phase >= 1 && m_phase <= 3), "R8 busy", 32'(busy), 32'(m_phase >= 1 && m_phase <= 3));
        chk(err_state == (m_phase == 4), "R1 err_state", 32'(err_state), 32'(m_phase == 4));
        chk(rf_we == (m_phase == 1 || m_phase == 2), "R9 rf_we", 32'(rf_we), 32'(m_phase == 1 || m_phase == 2));
        chk(done == (m_phase == 3), "R8 done", 32'(done), 32'(m_phase == 3));
        if (m_phase == 1) begin
            chk(rf_win == m_win, "R2 rf_win", 32'(rf_win), 32'(m_win));
            chk(rf_local == 3'd1 && rf_wdata == m_pc, "R3 pc save", rf_wdata, m_pc);
        end
        if (m_phase == 2) begin
            chk(rf_win == m_win, "R2 rf_win", 32'(rf_win), 32'(m_win));
            chk(rf_local == 3'd2 && rf_wdata == m_npc, "R4 npc save", rf_wdata, m_npc);
        end
        if (m_phase == 3) begin
            chk(new_cwp == m_win, "R2 new_cwp", 32'(new_cwp), 32'(m_win));
            chk(new_psup == m_psup && new_sup && !new_et, "R5 state bits",
                {29'd0, new_psup, new_sup, new_et}, {29'd0, m_psup, 1'b1, 1'b0});
            chk(new_tbr == m_tbr, "R6 tbr", new_tbr, m_tbr);
            chk(new_pc == m_tbr, "R7 pc", new_pc, m_tbr);
            chk(new_npc == m_tbr + 32'd4, "R7 npc", new_npc, m_tbr + 32'd4);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        cycles++;
        @(negedge clk);
        compare();
    endtask

    task automatic trap(input logic [2:0] cwp, input logic [7:0] tt, input logic [31:0] pc,
                        input logic sup, input logic et, input logic [19:0] base);
        trap_req = 1'b1; cwp_in = cwp; trap_num = tt; pc_in = pc; npc_in = pc + 4;
        sup_in = sup; et_in = et; tbr_base_in = base;
        tick();
        trap_req = 1'b0;
    endtask

    // Watchdog: counts as a failed check
    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected<20000", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; trap_req = 1'b0; trap_num = '0; pc_in = '0; npc_in = '0;
        cwp_in = '0; sup_in = 1'b0; et_in = 1'b1; tbr_base_in = '0;
        m_phase = 0; m_pc = '0; m_npc = '0; m_tbr = '0; m_win = '0; m_psup = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        // R10: reset state
        @(negedge clk);
        chk(!busy && !rf_we && !done && !err_state, "R10 reset idle",
            {28'd0, busy, rf_we, done, err_state}, 32'd0);
        tick();
        // R2 wrap from 0 to NWIN-1, trap number 0
        trap(3'd0, 8'h00, 32'h0000_1000, 1'b0, 1'b1, 20'hABCDE);
        repeat (4) tick();
        // Ordinary window and max trap number
        trap(3'd5, 8'hFF, 32'h4000_0020, 1'b1, 1'b1, 20'h12345);
        repeat (4) tick();
        // R9: conflicting requests during the sequence
        trap(3'd3, 8'h11, 32'h0000_2000, 1'b1, 1'b1, 20'h00001);
        trap_req = 1'b1; cwp_in = 3'd0; trap_num = 8'h99; pc_in = 32'hDEAD_BEE0;
        npc_in = 32'hDEAD_BEE4; sup_in = 1'b0; tbr_base_in = 20'hFFFFF;
        repeat (3) tick();
        trap_req = 1'b0;
        repeat (2) tick();
        // Several distinct patterns
        for (int i = 0; i < 12; i++) begin
            trap(3'(i * 3), 8'(i * 37 + 5), 32'(32'h1000_0000 + i * 32'h44), 1'(i), 1'b1, 20'(i * 20'h1357));
            repeat (i % 3 + 3) tick();
        end
        // Back-to-back: request held high through the end of a sequence
        trap_req = 1'b1; et_in = 1'b1; cwp_in = 3'd1; trap_num = 8'h42;
        pc_in = 32'h0000_8000; npc_in = 32'h0000_8004; sup_in = 1'b1; tbr_base_in = 20'h00F00;
        repeat (9) tick();
        trap_req = 1'b0;
        repeat (4) tick();
        // R1: traps disabled -> error state, further requests ignored
        trap(3'd2, 8'h07, 32'h0000_3000, 1'b1, 1'b0, 20'h00010);
        repeat (2) tick();
        trap(3'd4, 8'h08, 32'h0000_4000, 1'b1, 1'b1, 20'h00020);
        repeat (4) tick();
        chk(err_state && !rf_we && !done, "R1 error sticky",
            {29'd0, err_state, rf_we, done}, 32'd4);
        // R10: reset leaves the error state
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        tick();
        chk(!err_state && !busy, "R10 reset clears error", {30'd0, err_state, busy}, 32'd0);
        trap(3'd7, 8'h80, 32'h0000_5000, 1'b0, 1'b1, 20'h0BEEF);
        repeat (5) tick();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule